// File: doc/BRIEF.md
# Context Sequencer with Cross-Array Handshake

This block steps a reconfigurable array through its stored contexts. It holds a small context store, one word per context, and drives a pointer that selects the active word. Each word carries its own sequencing control in its low bits: the pointer of the context to run next, a flag that asks for a handshake, and a mask that picks which ready lines from neighbouring arrays must be high. The controller runs on its own; it never waits for another array unless the current context asks it to.

A start pulse launches a task at entry 0. From then on the pointer moves to the next context on every clock edge. When a context asks for a handshake, the move is held back until every masked ready line is high. A context that names itself as its successor ends the task. The controller then raises done and holds the pointer there until the next start.

A write port lets a loader fill entries for the next task while the current one runs. Any entry may be written, except the one being executed. A write to that entry is dropped and reported.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: After reset, ctx_ptr is 0, done is 0, wr_err is 0, and the controller is idle, not running.
- R2: A start pulse while idle or done makes the controller run from entry 0. After the next edge, ctx_ptr is 0 and done is 0.
- R3: Word layout: bits [4:0] hold the next pointer, bit 5 is the wait flag, and bits [9:6] are the ready mask. While running, when the next pointer differs from ctx_ptr and no wait is in force, ctx_ptr takes the next pointer at the following edge. This is one switch per clock.
- R4: When the wait flag is set, the switch happens only on an edge where (ready & mask) == mask. At every other edge, ctx_ptr holds its value. A mask of 0 never stalls.
- R5: A running context whose next pointer equals its own index ends the task. done goes high at the following edge, whatever the handshake state. After that, ctx_ptr and done hold until a start pulse.
- R6: A write while not running stores to any entry. A write while running stores to any entry other than ctx_ptr. The stored word takes effect from the next edge.
- R7: A write while running whose address equals ctx_ptr is dropped. wr_err is high for exactly the cycle after it. In all other cases wr_err is low.
- R8: A start pulse while running has no effect on ctx_ptr or the sequence.
- R9: ctx_word always shows the full stored word at entry ctx_ptr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a task at entry 0 |
| ready | input | 4 | Ready lines from connected arrays |
| wr_en | input | 1 | Loader write strobe |
| wr_addr | input | 5 | Loader write entry |
| wr_data | input | 64 | Loader write word |
| ctx_ptr | output | 5 | Active context pointer |
| ctx_word | output | 64 | Stored word at the active context |
| done | output | 1 | Task finished (end marker reached) |
| wr_err | output | 1 | Previous-cycle write hit the active entry and was dropped |

## Verification
Results fall due as follows, each exactly one rising edge after its cause:
- ctx_ptr is due after a start pulse or a switch decision.
- done is due after the pointer lands on an end marker.
- wr_err is due after a write strobe.
- A stored word is visible on ctx_word from the edge that writes it.

The bench drives every input 1 ns after a rising edge and samples 1 ns after the next one, so each check sees exactly the registers updated by that edge. It sweeps all 256 mask and ready pairs on a waiting context. It walks a 32-step chain that visits every entry. It also exercises writes against a stalled context.

// File: rtl/ctxc_pkg.sv
package ctxc_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_mode_e;
endpackage

// File: rtl/ctx_store.sv
module ctx_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ctx_gate.sv
module ctx_gate #(
    parameter int NREADY = 4
) (
    input  logic              wait_en,
    input  logic [NREADY-1:0] mask,
    input  logic [NREADY-1:0] ready,
    output logic              go
);
    logic [NREADY-1:0] sat;

    // Each lane is satisfied when it is not selected or its neighbour is ready.
    for (genvar i = 0; i < NREADY; i++) begin : g_lane
        assign sat[i] = ~mask[i] | ready[i];
    end

    assign go = ~wait_en | (&sat);
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctxc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] nxt,
    input  logic          go,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    output logic [AW-1:0] ptr,
    output logic          running,
    output logic          done,
    output logic          wr_block,
    output logic          wr_err
);
    typedef struct packed {
        seq_mode_e     mode;
        logic [AW-1:0] ptr;
        logic          err;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       hit_d;
    logic       end_d;

    always_comb begin
        st_d   = st_q;
        hit_d  = wr_en && (st_q.mode == SEQ_RUN) && (wr_addr == st_q.ptr);
        end_d  = (nxt == st_q.ptr);
        st_d.err = hit_d;
        case (st_q.mode)
            SEQ_RUN: begin
                if (end_d) begin
                    st_d.mode = SEQ_DONE;
                end else if (go) begin
                    st_d.ptr = nxt;
                end
            end
            default: begin
                if (start) begin
                    st_d.mode = SEQ_RUN;
                    st_d.ptr  = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= SEQ_IDLE;
            st_q.ptr  <= '0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr      = st_q.ptr;
    assign running  = (st_q.mode == SEQ_RUN);
    assign done     = (st_q.mode == SEQ_DONE);
    assign wr_block = hit_d;
    assign wr_err   = st_q.err;

    // R3: an unblocked switch lands on the programmed successor
    a_r3_switch_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (nxt != ptr) && go) |=> (ptr == $past(nxt)));

    // R4: a stalled context keeps its pointer and keeps running
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (nxt != ptr) && !go) |=> (running && $stable(ptr)));

    // R5: end marker finishes the task, done then persists without start
    a_r5_end_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (nxt == ptr)) |=> (done && $stable(ptr)));
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(ptr)));

    // R7: a hit on the active entry is flagged one cycle later, nothing else is
    a_r7_err_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && running && (wr_addr == ptr)) |=> wr_err);
    a_r7_no_false_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && running && (wr_addr == ptr)) |=> !wr_err);

    // R8: start while running does not reload the pointer of a stalled context
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !go && (nxt != ptr)) |=> $stable(ptr));
endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 64,
    parameter int NREADY = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NREADY-1:0] ready,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [AW-1:0]     ctx_ptr,
    output logic [WIDTH-1:0]  ctx_word,
    output logic              done,
    output logic              wr_err
);
    // Control fields in the low bits of every context word.
    localparam int NEXT_LSB = 0;
    localparam int WAIT_BIT = NEXT_LSB + AW;
    localparam int MASK_LSB = WAIT_BIT + 1;

    logic [AW-1:0]     nxt_f;
    logic              wait_f;
    logic [NREADY-1:0] mask_f;
    logic              go;
    logic              running;
    logic              wr_block;
    logic              store_we;

    assign nxt_f  = ctx_word[NEXT_LSB +: AW];
    assign wait_f = ctx_word[WAIT_BIT];
    assign mask_f = ctx_word[MASK_LSB +: NREADY];
    assign store_we = wr_en & ~wr_block;

    ctx_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
        .clk   (clk),
        .we    (store_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (ctx_ptr),
        .rdata (ctx_word)
    );

    ctx_gate #(.NREADY(NREADY)) gate_i (
        .wait_en (wait_f),
        .mask    (mask_f),
        .ready   (ready),
        .go      (go)
    );

    ctx_seq #(.AW(AW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .nxt      (nxt_f),
        .go       (go),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .ptr      (ctx_ptr),
        .running  (running),
        .done     (done),
        .wr_block (wr_block),
        .wr_err   (wr_err)
    );

    // R6: the active entry's word is unchanged across a running cycle with a hit
    a_r6_active_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && (wr_addr == ctx_ptr) && !go && (nxt_f != ctx_ptr))
            |=> $stable(ctx_word));
endmodule

// File: tb/ctx_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module ctx_switch_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  ready = 4'h0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  ctx_ptr;
    logic [63:0] ctx_word;
    logic        done;
    logic        wr_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [63:0] model [32];

    always #4 clk = ~clk;

    ctx_switch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctx_ptr(ctx_ptr), .ctx_word(ctx_word), .done(done), .wr_err(wr_err)
    );

    function automatic logic [63:0] mk(input int nxt, input bit wt, input int msk, input int tag);
        logic [63:0] w = '0;
        w[4:0]   = nxt[4:0];
        w[5]     = wt;
        w[9:6]   = msk[3:0];
        w[63:32] = 32'hA5000000 + tag;
        return w;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a[4:0]; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic kick();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog got=%0d exp=<150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int exp;
        tick(); tick();
        // R1: reset state
        chk("R1 ptr", ctx_ptr, 0);
        chk("R1 done", done, 0);
        chk("R1 err", wr_err, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle ptr", ctx_ptr, 0);

        // Chain: every entry steps by 7, entry 25 is the end marker.
        for (int i = 0; i < 32; i++) begin
            model[i] = mk((i == 25) ? 25 : (i + 7) % 32, 0, 0, i);
            wr(i, model[i]);
        end
        chk("R6 idle write err", wr_err, 0);
        kick();
        chk("R2 start ptr", ctx_ptr, 0);
        chk("R9 word", ctx_word, model[0]);
        exp = 0;
        for (int k = 1; k < 32; k++) begin
            if (k == 10) start = 1'b1;  // R8: start while running
            tick();
            start = 1'b0;
            exp = (exp + 7) % 32;
            chk((k == 10) ? "R8 start ignored" : "R3 step", ctx_ptr, exp);
            chk("R9 word", ctx_word, model[exp]);
        end
        chk("R5 not yet done", done, 0);
        tick();
        chk("R5 done", done, 1);
        chk("R5 ptr held", ctx_ptr, 25);
        tick(); tick();
        chk("R5 done sticky", done, 1);
        chk("R5 ptr sticky", ctx_ptr, 25);

        // Mask / ready sweep on a waiting context.
        wr(1, mk(1, 0, 0, 1));
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 16; r++) begin
                bit ok;
                ok = ((r & m) == m);
                wr(0, mk(1, 1, m, 0));
                ready = r[3:0];
                kick();
                chk("R2 restart ptr", ctx_ptr, 0);
                chk("R2 restart done", done, 0);
                tick();
                chk("R4 gate", ctx_ptr, ok ? 1 : 0);
                if (!ok) begin
                    tick();
                    chk("R4 hold", ctx_ptr, 0);
                    ready = 4'hF;
                    tick();
                    chk("R4 release", ctx_ptr, 1);
                end
                tick();
                chk("R5 done after wait", done, 1);
                ready = 4'h0;
            end
        end

        // Writes against a stalled context.
        wr(0, mk(1, 1, 1, 0));
        wr(1, mk(2, 0, 0, 1));
        wr(2, mk(2, 0, 0, 2));
        ready = 4'h0;
        kick();
        chk("R4 stalled", ctx_ptr, 0);
        wr(0, mk(5, 0, 0, 9));
        chk("R7 err pulse", wr_err, 1);
        chk("R7 word kept", ctx_word, mk(1, 1, 1, 0));
        tick();
        chk("R7 err cleared", wr_err, 0);
        wr(2, mk(3, 0, 0, 2));
        chk("R6 running write err", wr_err, 0);
        wr(3, mk(3, 0, 0, 3));
        ready = 4'h1;
        tick();
        chk("R7 dropped write", ctx_ptr, 1);
        tick();
        chk("R6 path", ctx_ptr, 2);
        chk("R6 new word", ctx_word, mk(3, 0, 0, 2));
        tick();
        chk("R6 background", ctx_ptr, 3);
        tick();
        chk("R5 end", done, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule